// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is a shift register with a parameterised number of stages (eight by default). It either captures a parallel word into all stages at once, or moves the stored word one stage toward the output end while a serial bit enters at the start. The last stage is driven out twice: once as it is, and once inverted. The full stage vector is also exposed so that neighbouring logic or a bench can observe it.

Every external pin is sampled by a fast system clock through a two-flop synchroniser. The two clock pins are combined with a logical OR. A shift happens on a low-to-high transition of that OR, found by comparing the synchronised OR with its value one system cycle earlier. Because of the OR, either pin can serve as the shift clock while the other acts as an inhibit. The active-low load control is level-sensitive and takes priority over both clock pins. The OR history keeps updating during a load, so that ending a load while a clock pin is already high does not cause a shift.

Top module: `pload_shreg`

## Requirements
- R1: While the synchronised `ld_n` is low, every stage takes the synchronised value of its parallel input on each system clock. Clock-pin activity during that time has no effect.
- R2: While `ld_n` is high, the register shifts by exactly one position for each low-to-high transition of (`ck_a` OR `ck_b`). Either pin may act as the clock.
- R3: On a shift, `ser_in` enters stage 0. Stage i (i>0) takes the previous value of stage i-1, and the old value of stage W-1 is discarded.
- R4: While one clock pin is held high, rising edges on the other pin cause no shift.
- R5: While `ld_n` is high and no rising edge of the OR occurs, all stages keep their values, whatever `ser_in` and `par_in` do.
- R6: `q_last` equals stage W-1, and `q_last_n` is its complement.
- R7: Bit i of `par_in` loads stage i. Stage 0 is the serial entry end and stage W-1 is the output end (`stages[i]` is stage i).
- R8: Raising `ld_n` while the OR of the clock pins is already high does not cause a shift.
- R9: A synchronous active-high `rst` clears all stages, the synchroniser and the edge history. The synchroniser comes out of reset in shift mode with both clock pins low, so `q_last` is 0 and `q_last_n` is 1 after reset.
- R10: A pin change becomes visible on `stages` at the third rising edge of `clk` after the change: two synchroniser flops, then the stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| ck_a | input | 1 | Clock pin A, ORed with B |
| ck_b | input | 1 | Clock pin B, ORed with A |
| ld_n | input | 1 | Low: parallel load; high: shift mode |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | W | Parallel data, bit i to stage i |
| q_last | output | 1 | Last stage (W-1) |
| q_last_n | output | 1 | Complement of the last stage |
| stages | output | W | Full stage vector |

## Verification
The bench toggles one clock pin while a load is active; a design that let the clock win would show shifted data instead of the parallel word. It ends a load with a clock pin already high; a design that cleared its edge history during the load would report a false shift there. It holds pin A high while pin B pulses, and then swaps the two pins' roles. A design that used only one pin as the clock, or that detected edges on each pin separately, would shift when it should not or miss edges. It also checks the serial bit order, the bit order of the parallel inputs, and the exact three-cycle latency. A reversed stage index or an extra synchroniser stage would then show up directly.

// File: rtl/pload_shreg.sv
module pload_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ck_a,
  input  logic         ck_b,
  input  logic         ld_n,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic         q_last,
  output logic         q_last_n,
  output logic [W-1:0] stages
);
  localparam int SW = W + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(4);

  logic [SW-1:0] s1, s2;
  logic          ca_s, cb_s, ld_s, ser_s;
  logic [W-1:0]  par_s;
  logic          gclk, gclk_d, shift_ev;
  logic [W-1:0]  st;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= {par_in, ser_in, ld_n, ck_b, ck_a};
      s2 <= s1;
    end
  end

  assign ca_s  = s2[0];
  assign cb_s  = s2[1];
  assign ld_s  = s2[2];
  assign ser_s = s2[3];
  assign par_s = s2[SW-1:4];

  assign gclk     = ca_s | cb_s;
  assign shift_ev = ld_s & gclk & ~gclk_d;

  always_ff @(posedge clk) begin
    if (rst) gclk_d <= 1'b0;
    else     gclk_d <= gclk;
  end

  always_ff @(posedge clk) begin
    if (rst)           st <= '0;
    else if (!ld_s)    st <= par_s;
    else if (shift_ev) st <= {st[W-2:0], ser_s};
  end

  assign stages   = st;
  assign q_last   = st[W-1];
  assign q_last_n = ~st[W-1];
endmodule

module pload_shreg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_s,
  input logic         ca_s,
  input logic         cb_s,
  input logic         ser_s,
  input logic [W-1:0] par_s,
  input logic         gclk_d,
  input logic [W-1:0] stages
);
  a_r1_load_follows: assert property (@(posedge clk) disable iff (rst)
    !ld_s |=> stages == $past(par_s));

  a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
    (ld_s && (ca_s || cb_s) && !gclk_d) |=> stages == {$past(stages[W-2:0]), $past(ser_s)});

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (ld_s && !((ca_s || cb_s) && !gclk_d)) |=> $stable(stages));

  a_r4_inhibit: assert property (@(posedge clk) disable iff (rst)
    (ld_s && ca_s && $past(ca_s) && $rose(cb_s)) |=> $stable(stages));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> stages == '0);
endmodule

bind pload_shreg pload_shreg_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ld_s(ld_s), .ca_s(ca_s), .cb_s(cb_s),
  .ser_s(ser_s), .par_s(par_s), .gclk_d(gclk_d), .stages(stages)
);

// File: tb/pload_shreg_tb_top.sv
module pload_shreg_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, ck_a, ck_b, ld_n, ser_in;
  logic [W-1:0] par_in;
  logic q_last, q_last_n;
  logic [W-1:0] stages;

  always #5 clk = ~clk;

  pload_shreg #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .ck_a(ck_a), .ck_b(ck_b), .ld_n(ld_n),
    .ser_in(ser_in), .par_in(par_in), .q_last(q_last),
    .q_last_n(q_last_n), .stages(stages)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t        sb[$];
  int           n_vec = 0;
  int           n_bad = 0;
  logic [W-1:0] model = '0;
  logic         gprev = 1'b0;

  task automatic check_now(input logic [W-1:0] exp, input string tag);
    n_vec++;
    if (stages !== exp || q_last !== exp[W-1] || q_last_n !== ~exp[W-1]) begin
      n_bad++;
      $display("FAIL %s: stages=%b q=%b qn=%b expected stages=%b q=%b qn=%b",
               tag, stages, q_last, q_last_n, exp, exp[W-1], ~exp[W-1]);
    end
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      check_now(it.exp, it.tag);
    end
  end

  // driver: apply a pin state, update the reference model, push expectation
  task automatic step(input logic a, input logic b, input logic l,
                      input logic s, input logic [W-1:0] p, input string tag);
    logic g;
    item_t it;
    @(negedge clk);
    ck_a = a; ck_b = b; ld_n = l; ser_in = s; par_in = p;
    g = a | b;
    if (!l)              model = p;
    else if (g && !gprev) model = {model[W-2:0], s};
    gprev = g;
    repeat (4) @(negedge clk);
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    rst = 1'b1; ck_a = 0; ck_b = 0; ld_n = 1; ser_in = 0; par_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now('0, "R9 reset state");

    // R1: load with clock pin toggling
    step(0, 0, 0, 1, 8'hA5, "R1 load");
    step(1, 0, 0, 1, 8'hA5, "R1 clock ignored in load");
    step(0, 0, 0, 1, 8'hA5, "R1 clock ignored in load");
    step(1, 0, 0, 0, 8'h3C, "R1 load follows new word");
    // R8: release with ck_a already high
    step(1, 0, 1, 1, 8'h00, "R8 release with clock high");
    step(0, 0, 1, 1, 8'h00, "R8 falling edge no shift");
    // R2/R6: shift 3C out with ck_a
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 1, 0, 8'h00, "R2 R6 shift out via pin A");
      step(0, 0, 1, 0, 8'h00, "R5 hold between edges");
    end
    // R3: serial in via ck_b
    pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 1, pat[i], 8'h00, "R3 serial in via pin B");
      step(0, 0, 1, ~pat[i], 8'hFF, "R5 hold ignores ser and par");
    end
    // R4: ck_a high inhibits ck_b
    step(1, 0, 1, 1, 8'h00, "R2 edge on pin A");
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1, 1, 8'h00, "R4 pin B inhibited by A");
      step(1, 0, 1, 0, 8'h00, "R4 pin B inhibited by A");
    end
    step(0, 0, 1, 0, 8'h00, "R5 hold");
    // swapped roles: ck_b high inhibits ck_a
    step(0, 1, 1, 1, 8'h00, "R2 edge on pin B");
    step(1, 1, 1, 0, 8'h00, "R4 pin A inhibited by B");
    step(0, 1, 1, 0, 8'h00, "R4 pin A inhibited by B");
    step(0, 0, 1, 0, 8'h00, "R5 hold");
    // R7: bit mapping
    step(0, 0, 0, 0, 8'h01, "R7 par bit0 to stage0");
    step(0, 0, 0, 0, 8'h80, "R7 par bit7 to last stage");
    step(0, 0, 1, 0, 8'h80, "R6 outputs from last stage");
    wait (sb.size() == 0);
    #2;
    // R10 latency: change at negedge, visible at third posedge
    @(negedge clk);
    ld_n = 0; par_in = 8'h5A;
    @(posedge clk); @(posedge clk); #1;
    check_now(8'h80, "R10 not yet visible after two edges");
    @(posedge clk); #1;
    check_now(8'h5A, "R10 visible after third edge");
    model = 8'h5A;
    step(0, 0, 0, 0, 8'h5A, "R10 stays loaded");
    wait (sb.size() == 0);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule